// File: doc/BRIEF.md
# Ethernet Controller Interrupt Status Unit

This unit holds the eight-bit interrupt status word and the eight-bit interrupt enable mask of a small Ethernet controller, and it drives one level-sensitive interrupt line toward the host. The receive path, the transmit path and the buffer allocator report events as single-cycle pulses on a set vector. Two status bits also follow queue levels supplied by the transmit logic. The transmit-empty bit is set while the transmit queue holds nothing. The transmit-complete bit is set while the completion queue holds at least one entry.

Software reaches the unit through a byte-wide register port with one select line. With select 0, a read returns the status and a write acts as an acknowledge. With select 1, the mask is read and written. An acknowledge can clear only a fixed subset of status bits. An acknowledge that carries bit 1 also sends a one-cycle pop request to the completion queue, which sits outside this unit. The interrupt line is registered.

Top module: `eth_irq_ctrl`

## Requirements
- R1: After reset the status reads 0x04, the mask reads 0x00, `irq_o` is low and `done_pop_o` is low.
- R2: The status bit order is: bit0 frame received, bit1 transmit complete, bit2 transmit queue empty, bit3 buffer allocated, bit4 receive overrun, bit5 PHY event, bit6 early receive, bit7 management event. A pulse on `evt_i[k]` sets status bit k on the next clock edge. Any other bit that is set stays set.
- R3: In every cycle in which `txq_empty_i` is high, status bit 2 is set on the following edge, and an acknowledge cannot clear it.
- R4: In every cycle in which `done_pend_i` is high, status bit 1 is set on the following edge, and an acknowledge cannot clear it.
- R5: A write with `reg_sel_i`=0 clears the status bits given by `reg_wdata_i & 0xD6`. Bits 0, 3 and 5 are never cleared by such a write.
- R6: `done_pop_o` is high for exactly the one cycle after a write with `reg_sel_i`=0 whose data has bit 1 set. It stays low after any other write.
- R7: A write with `reg_sel_i`=1 loads the mask, and a read with `reg_sel_i`=1 returns it. A read with `reg_sel_i`=0 returns the status.
- R8: `irq_o` equals the OR of (status AND mask) as they stood one cycle earlier, so it follows any status or mask change with one cycle of delay.
- R9: When an event pulse and an acknowledge of the same bit fall in the same cycle, the bit ends up set.
- R10: A mask write leaves the status unchanged, and a write with select 0 leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 8 | Single-cycle event pulses; each one sets the status bit at the same position |
| txq_empty_i | input | 1 | High while the transmit queue is empty |
| done_pend_i | input | 1 | High while the completion queue is not empty |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects status/acknowledge, 1 selects the mask |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register |
| done_pop_o | output | 1 | One-cycle request to pop the completion queue |
| irq_o | output | 1 | Registered interrupt line |

## Verification
Two functions can fall in the same cycle: an acknowledge write and a set request on the same status bit. The set request comes either from an event pulse or from a held queue level. The bench drives both in the same clock cycle, once with `evt_i` and once with `txq_empty_i` or `done_pend_i` held high. It then reads the status back and expects the bit to still be set. When only the acknowledge is repeated, the bit must clear. The same acknowledges are also checked for their pop pulse on the following cycle.

// File: rtl/eth_irq_pkg.sv
package eth_irq_pkg;
  localparam int STS_W = 8;
  localparam int BIT_TXDONE = 1;
  localparam int BIT_TXEMPTY = 2;
  localparam logic [STS_W-1:0] ACK_CLEARABLE = 8'hD6;
  localparam logic [STS_W-1:0] RESET_STS = 8'h04;
  typedef enum logic {SEL_STATUS = 1'b0, SEL_MASK = 1'b1} reg_sel_e;
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] ACK_MASK = '1,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter int EMPTY_BIT = 2,
  parameter int DONE_BIT = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         ack_we_i,
  input  logic [W-1:0] ack_val_i,
  input  logic         txq_empty_i,
  input  logic         done_pend_i,
  output logic [W-1:0] sts_o
);
  logic [W-1:0] sts_q, sts_d, clr_v, force_v;
  logic         sts_en;

  // Level-forced bits, one slot per position.
  for (genvar k = 0; k < W; k++) begin : g_force
    if (k == EMPTY_BIT) begin : g_empty
      assign force_v[k] = txq_empty_i;
    end else if (k == DONE_BIT) begin : g_done
      assign force_v[k] = done_pend_i;
    end else begin : g_none
      assign force_v[k] = 1'b0;
    end
  end

  always_comb begin
    clr_v  = ack_we_i ? (ack_val_i & ACK_MASK) : '0;
    // Set sources are applied after the clear, so they win.
    sts_d  = (sts_q & ~clr_v) | evt_i | force_v;
    sts_en = (sts_d != sts_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= RST_VAL;
    else if (sts_en) sts_q <= sts_d;
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_q <= '0;
    else if (we_i) mask_q <= wdata_i;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_out_gen.sv
module irq_out_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sts_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o
);
  logic irq_q, irq_d;

  always_comb irq_d = |(sts_i & mask_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/eth_irq_ctrl.sv
module eth_irq_ctrl
  import eth_irq_pkg::*;
#(
  parameter int W = STS_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         txq_empty_i,
  input  logic         done_pend_i,
  input  logic         reg_we_i,
  input  logic         reg_sel_i,
  input  logic [W-1:0] reg_wdata_i,
  output logic [W-1:0] reg_rdata_o,
  output logic         done_pop_o,
  output logic         irq_o
);
  logic [W-1:0] sts_q, mask_q;
  logic         ack_we, mask_we, pop_d, pop_q;

  always_comb begin
    ack_we  = reg_we_i && (reg_sel_i == SEL_STATUS);
    mask_we = reg_we_i && (reg_sel_i == SEL_MASK);
    pop_d   = ack_we && reg_wdata_i[BIT_TXDONE];
    reg_rdata_o = (reg_sel_i == SEL_MASK) ? mask_q : sts_q;
  end

  irq_status_reg #(
    .W(W), .ACK_MASK(ACK_CLEARABLE), .RST_VAL(RESET_STS),
    .EMPTY_BIT(BIT_TXEMPTY), .DONE_BIT(BIT_TXDONE)
  ) u_sts (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .ack_we_i(ack_we),
    .ack_val_i(reg_wdata_i), .txq_empty_i(txq_empty_i),
    .done_pend_i(done_pend_i), .sts_o(sts_q)
  );

  irq_mask_reg #(.W(W)) u_mask (
    .clk(clk), .rst_n(rst_n), .we_i(mask_we), .wdata_i(reg_wdata_i),
    .mask_o(mask_q)
  );

  irq_out_gen #(.W(W)) u_irq (
    .clk(clk), .rst_n(rst_n), .sts_i(sts_q), .mask_i(mask_q), .irq_o(irq_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pop_q <= 1'b0;
    else        pop_q <= pop_d;
  end

  assign done_pop_o = pop_q;
endmodule

// File: rtl/eth_irq_ctrl_chk.sv
module eth_irq_ctrl_chk
  import eth_irq_pkg::*;
#(
  parameter int W = STS_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] evt_i,
  input logic         txq_empty_i,
  input logic         done_pend_i,
  input logic         reg_we_i,
  input logic         reg_sel_i,
  input logic [W-1:0] reg_wdata_i,
  input logic [W-1:0] sts_i,
  input logic [W-1:0] mask_i,
  input logic         done_pop_o,
  input logic         irq_o
);
  localparam logic [W-1:0] KEEP_BITS = ~ACK_CLEARABLE;

  // R2 R9
  evt_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_i & $past(evt_i)) == $past(evt_i)));

  // R3
  txempty_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(txq_empty_i) |-> sts_i[BIT_TXEMPTY]);

  // R4
  txdone_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done_pend_i) |-> sts_i[BIT_TXDONE]);

  // R5
  sticky_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_i & $past(sts_i) & KEEP_BITS) == ($past(sts_i) & KEEP_BITS)));

  // R6
  pop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pop_o == $past(reg_we_i && (reg_sel_i == SEL_STATUS) && reg_wdata_i[BIT_TXDONE]));

  // R8
  irq_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == $past(|(sts_i & mask_i)));

  // R10
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_we_i && (reg_sel_i == SEL_MASK)) |-> $stable(mask_i));
endmodule

bind eth_irq_ctrl eth_irq_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .txq_empty_i(txq_empty_i),
  .done_pend_i(done_pend_i), .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i),
  .reg_wdata_i(reg_wdata_i), .sts_i(sts_q), .mask_i(mask_q),
  .done_pop_o(done_pop_o), .irq_o(irq_o)
);

// File: tb/test_eth_irq_ctrl.sv
`timescale 1ns/1ps
module test_eth_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] evt;
  logic       txq_empty, done_pend, reg_we, reg_sel;
  logic [7:0] wdata, rdata;
  logic       done_pop, irq;
  int checks = 0, errors = 0;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  eth_irq_ctrl i_eth_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .txq_empty_i(txq_empty),
    .done_pend_i(done_pend), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .done_pop_o(done_pop),
    .irq_o(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic read_reg(input logic sel, output logic [7:0] d);
    reg_sel = sel;
    #1;
    d = rdata;
  endtask

  task automatic reg_write(input logic sel, input logic [7:0] d, input logic [7:0] ev,
                           output logic pop_seen);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; wdata = d; evt = ev;
    @(negedge clk);
    reg_we = 1'b0; evt = 8'h00; wdata = 8'h00;
    pop_seen = done_pop;
  endtask

  task automatic pulse_evt(input logic [7:0] ev);
    @(negedge clk); evt = ev;
    @(negedge clk); evt = 8'h00;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    read_reg(1'b0, v); check("R1 status", v, 8'h04);
    read_reg(1'b1, v); check("R1 mask", v, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 pop", {7'd0, done_pop}, 8'h00);
  endtask

  task automatic t_events_ack;
    logic [7:0] v; logic p;
    @(negedge clk); txq_empty = 1'b0;
    pulse_evt(8'h81);
    read_reg(1'b0, v); check("R2 event set", v, 8'h85);
    reg_write(1'b0, 8'hFF, 8'h00, p);
    read_reg(1'b0, v); check("R5 ack clears D6 subset", v, 8'h01);
    check("R6 pop after ack bit1", {7'd0, p}, 8'h01);
    pulse_evt(8'h28);
    read_reg(1'b0, v); check("R2 second event", v, 8'h29);
    reg_write(1'b0, 8'hFF, 8'h00, p);
    read_reg(1'b0, v); check("R5 bits 0 3 5 survive ack", v, 8'h29);
  endtask

  task automatic t_txempty;
    logic [7:0] v; logic p;
    @(negedge clk); txq_empty = 1'b1;
    reg_write(1'b0, 8'h04, 8'h00, p);
    read_reg(1'b0, v); check("R3 empty bit held against ack", v, 8'h2D);
    check("R6 no pop without bit1", {7'd0, p}, 8'h00);
    @(negedge clk); txq_empty = 1'b0;
    reg_write(1'b0, 8'h04, 8'h00, p);
    read_reg(1'b0, v); check("R3 empty bit clears once level drops", v, 8'h29);
  endtask

  task automatic t_done;
    logic [7:0] v; logic p;
    @(negedge clk); done_pend = 1'b1;
    reg_write(1'b0, 8'h02, 8'h00, p);
    read_reg(1'b0, v); check("R4 done bit held against ack", v, 8'h2B);
    check("R6 pop with done pending", {7'd0, p}, 8'h01);
    @(negedge clk); done_pend = 1'b0;
    reg_write(1'b0, 8'h02, 8'h00, p);
    read_reg(1'b0, v); check("R4 done bit clears", v, 8'h29);
    check("R6 pop pulse", {7'd0, p}, 8'h01);
    @(negedge clk);
    check("R6 pop lasts one cycle", {7'd0, done_pop}, 8'h00);
  endtask

  task automatic t_mask_irq;
    logic [7:0] v; logic p;
    reg_write(1'b1, 8'h52, 8'h00, p);
    read_reg(1'b1, v); check("R7 mask readback", v, 8'h52);
    read_reg(1'b0, v); check("R10 status kept on mask write", v, 8'h29);
    check("R6 no pop on mask write", {7'd0, p}, 8'h00);
    @(negedge clk);
    check("R8 irq low when masked", {7'd0, irq}, 8'h00);
    pulse_evt(8'h10);
    check("R8 irq not yet high", {7'd0, irq}, 8'h00);
    @(negedge clk);
    check("R8 irq high one cycle later", {7'd0, irq}, 8'h01);
    reg_write(1'b1, 8'h00, 8'h00, p);
    check("R8 irq still high after mask write", {7'd0, irq}, 8'h01);
    @(negedge clk);
    check("R8 irq drops after mask clear", {7'd0, irq}, 8'h00);
    reg_write(1'b1, 8'hA5, 8'h00, p);
    reg_write(1'b0, 8'h10, 8'h00, p);
    read_reg(1'b1, v); check("R10 mask kept on ack write", v, 8'hA5);
    read_reg(1'b0, v); check("R5 overrun bit acked", v, 8'h29);
    reg_write(1'b1, 8'h00, 8'h00, p);
  endtask

  task automatic t_race;
    logic [7:0] v; logic p;
    reg_write(1'b0, 8'h10, 8'h10, p);
    read_reg(1'b0, v); check("R9 event beats ack bit4", v, 8'h39);
    reg_write(1'b0, 8'h10, 8'h00, p);
    read_reg(1'b0, v); check("R9 ack alone clears bit4", v, 8'h29);
    reg_write(1'b0, 8'h40, 8'h40, p);
    read_reg(1'b0, v); check("R9 event beats ack bit6", v, 8'h69);
    reg_write(1'b0, 8'h40, 8'h00, p);
    read_reg(1'b0, v); check("R9 ack alone clears bit6", v, 8'h29);
  endtask

  initial begin
    rst_n = 1'b0; evt = 8'h00; txq_empty = 1'b1; done_pend = 1'b0;
    reg_we = 1'b0; reg_sel = 1'b0; wdata = 8'h00;
    t_reset();
    t_events_ack();
    t_txempty();
    t_done();
    t_mask_irq();
    t_race();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule